// File: doc/BRIEF.md
# Vector Floating-Point Exception Trap Encoder

This block sits beside a vector floating-point datapath that produces its results one lane per cycle. For each lane the datapath reports five IEEE exception conditions (invalid operation, divide by zero, overflow, underflow, inexact) together with the index of the lane. The block holds the floating-point control word. It masks each lane's conditions with the trap-enable byte in that word and turns the most severe enabled condition into an 8-bit exception code. It also decides whether the operation may retire.

An operation starts with a one-cycle `op_start` that latches the lane count, single-element mode and inexact-trap suppression, and clears the flag accumulator. Lanes then arrive with `lane_valid`. The operation ends after the last lane, after lane 0 in single-element mode, or at the first lane that traps. A trap raises `trap_pulse` with the code, keeps the destination unwritten and leaves the control word alone. A clean finish raises `dest_we` and merges the OR of all lane conditions into the sticky flag byte of the control word.

Top module: `vfp_trap_encoder`

## Requirements
- R1: After reset the control word reads 0, `busy`, `trap_pulse`, `done` and `dest_we` are low and `trap_code` is 0.
- R2: A trap code is `{lane_idx (4 bits), cause (4 bits)}`, with cause 1 invalid, 2 divide-by-zero, 3 overflow, 4 underflow, 5 inexact. `trap_code` is 0 whenever `trap_pulse` is low.
- R3: The trap-enable byte is control bits 31:24. Its layout is invalid bit 7, divide-by-zero bit 6, overflow bit 5, underflow bit 4, inexact bit 3. `lane_flags` is ordered {invalid, divide-by-zero, overflow, underflow, inexact} from bit 4 down to bit 0. A condition whose enable bit is clear never traps.
- R4: When several enabled conditions are present, the cause is picked in this order: invalid, then divide-by-zero, then overflow, then underflow, then inexact.
- R5: With `op_no_inexact_trap` set at start, an enabled inexact condition with no other enabled condition causes no trap. The other causes are unaffected.
- R6: A trapping lane ends the operation. `done` and `trap_pulse` rise together, and later `lane_valid` beats cause no pulse and no change to the control word until the next start.
- R7: With `op_single` set at start, the operation completes after the first accepted lane, whatever the lane count.
- R8: On a clean finish, control bits 23:16 become their old value ORed with the conditions of every lane of the operation, in the same bit layout as R3. The accumulator is cleared at start, so conditions of an earlier trapped operation are never merged.
- R9: On a trap, `dest_we` stays low and the control word is not changed.
- R10: `lane_valid` while no operation is active has no effect on any output.
- R11: `ctrl_wr_en` loads `ctrl_wr_data` into the whole control word on the next edge.
- R12: `done` (with `dest_we` or `trap_pulse`) is a one-cycle pulse in the cycle after the final lane is accepted. It stays low while earlier lanes are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr_en | input | 1 | Load the control word |
| ctrl_wr_data | input | 32 | Value for the control word |
| ctrl_q | output | 32 | Control word: enables 31:24, sticky flags 23:16 |
| op_start | input | 1 | Begin an operation, latch configuration |
| op_single | input | 1 | Single-element mode |
| op_no_inexact_trap | input | 1 | Suppress inexact-only traps |
| op_lane_count | input | 3 | Lanes in this operation (1..LANES) |
| lane_valid | input | 1 | Lane result conditions valid |
| lane_idx | input | 2 | Index of the lane being reported |
| lane_flags | input | 5 | {invalid, div0, overflow, underflow, inexact} |
| busy | output | 1 | Operation in progress |
| trap_pulse | output | 1 | One-cycle trap indication |
| trap_code | output | 8 | Lane index and cause of the trap |
| done | output | 1 | Operation finished (one cycle) |
| dest_we | output | 1 | Destination may be written (clean finish) |

## Verification
Every result of a lane is registered once: `trap_pulse`, `trap_code`, `done`, `dest_we` and the merged control word all show the effect of a lane accepted at one clock edge right after that edge, and they last until the next edge. The bench drives inputs on the falling edge and samples all outputs one full cycle later on the next falling edge. This is the middle of the only cycle in which the pulses are high. A control-word write follows the same one-edge rule. For lanes that must have no effect, the bench samples the pulses and the control word in the cycle that lane would have produced its result.

// File: rtl/vfte_pkg.sv
// Shared types and helpers for the vector FP trap encoder.
// Assumes five exception conditions per lane, ordered by trap priority.
package vfte_pkg;

    localparam int COND_N    = 5;   // conditions reported per lane
    localparam int CTRL_W    = 32;  // control word width
    localparam int EN_LSB    = 24;  // trap-enable byte position
    localparam int STICKY_LSB = 16; // sticky flag byte position

    typedef logic [COND_N-1:0] cond_t;  // {inv, dz, ovf, unf, inx}
    typedef logic [7:0]        cbyte_t; // inv=7 .. inx=3, 2:0 unused

    typedef enum logic [3:0] {
        CAUSE_NONE  = 4'd0,
        CAUSE_INV   = 4'd1,
        CAUSE_DZ    = 4'd2,
        CAUSE_OVF   = 4'd3,
        CAUSE_UNF   = 4'd4,
        CAUSE_INX   = 4'd5
    } cause_e;

    // Place the five lane conditions into the control-byte layout.
    function automatic cbyte_t cond_to_byte(cond_t c);
        return {c, 3'b000};
    endfunction

endpackage

// File: rtl/vfte_prio_enc.sv
// Priority encoder for one lane: masks the lane's conditions with the
// enable byte and builds {lane index, cause} for the most severe enabled
// condition. Purely combinational; assumes LANE_W <= 4.
module vfte_prio_enc
    import vfte_pkg::*;
#(
    parameter int LANE_W = 2
) (
    input  logic [LANE_W-1:0] lane_idx,
    input  cond_t             lane_flags,
    input  cbyte_t            en_byte,
    input  logic              sup_inexact,
    output logic [7:0]        code,
    output logic              trap
);

    localparam int IDX_FIELD = 4;

    cbyte_t hit;
    logic [3:0] cause;

    // Walk from lowest to highest priority so the most severe bit wins.
    always_comb begin
        hit = cond_to_byte(lane_flags) & en_byte;
        if (sup_inexact) begin
            hit[3] = 1'b0;
        end
        cause = CAUSE_NONE;
        for (int k = 3; k <= 7; k++) begin
            if (hit[k]) begin
                cause = 4'(8 - k);
            end
        end
    end

    // Pack the lane index above the cause; zero means no trap.
    always_comb begin
        trap = (cause != CAUSE_NONE);
        code = trap ? {IDX_FIELD'(lane_idx), cause} : 8'h00;
    end

    // Inexact cause never appears while it is suppressed.
    always_comb begin
        if (code[3:0] == CAUSE_INX) begin
            AST_INX_SUPPRESSED: assert (!sup_inexact); // R5
        end
    end

endmodule

// File: rtl/vfte_lane_seq.sv
// Lane sequencer: latches the operation setup, accumulates lane conditions,
// and decides when the operation ends (trap, single element, last lane).
// Assumes one lane per lane_valid beat and lanes ignored while idle.
module vfte_lane_seq
    import vfte_pkg::*;
#(
    parameter int LANES = 4,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_start,
    input  logic             op_single,
    input  logic             op_no_inexact_trap,
    input  logic [CNT_W-1:0] op_lane_count,
    input  logic             lane_valid,
    input  cond_t            lane_flags,
    input  logic             lane_trap,
    input  logic [7:0]       lane_code,
    output logic             sup_cfg,
    output logic             busy,
    output logic             trap_pulse,
    output logic [7:0]       trap_code,
    output logic             done,
    output logic             dest_we,
    output logic             merge_en,
    output cbyte_t           merge_flags
);

    logic             single_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] seen_q;
    cbyte_t           acc_q;
    logic             accept;
    logic             last_lane;
    logic             finish;

    // Decide whether the lane on the inputs ends the operation.
    always_comb begin
        accept      = busy && lane_valid;
        last_lane   = (CNT_W'(seen_q + 1'b1) >= count_q);
        finish      = accept && (lane_trap || single_q || last_lane);
        merge_en    = finish && !lane_trap;
        merge_flags = acc_q | cond_to_byte(lane_flags);
    end

    // Operation state, accumulator and registered result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            single_q   <= 1'b0;
            sup_cfg    <= 1'b0;
            count_q    <= '0;
            seen_q     <= '0;
            acc_q      <= '0;
            trap_pulse <= 1'b0;
            trap_code  <= '0;
            done       <= 1'b0;
            dest_we    <= 1'b0;
        end else begin
            trap_pulse <= 1'b0;
            trap_code  <= '0;
            done       <= 1'b0;
            dest_we    <= 1'b0;
            if (op_start) begin
                busy     <= 1'b1;
                single_q <= op_single;
                sup_cfg  <= op_no_inexact_trap;
                count_q  <= op_lane_count;
                seen_q   <= '0;
                acc_q    <= '0;
            end else if (accept) begin
                seen_q <= seen_q + 1'b1;
                acc_q  <= merge_flags;
                if (finish) begin
                    busy       <= 1'b0;
                    done       <= 1'b1;
                    trap_pulse <= lane_trap;
                    trap_code  <= lane_trap ? lane_code : 8'h00;
                    dest_we    <= !lane_trap;
                end
            end
        end
    end

    AST_TRAP_ENDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> (done && !dest_we)); // R9
    AST_CODE_ONLY_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_pulse |-> (trap_code == 8'h00)); // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && single_q && lane_valid && !op_start) |=> (done && !busy)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !op_start) |=> !done); // R10

endmodule

// File: rtl/vfte_ctrl_reg.sv
// Control word: trap enables in the top byte, sticky flags below them.
// Software writes take priority over a same-cycle flag merge.
module vfte_ctrl_reg
    import vfte_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              merge_en,
    input  cbyte_t            merge_flags,
    output logic [CTRL_W-1:0] ctrl_q,
    output cbyte_t            en_byte
);

    // Hold the control word; OR merged flags into the sticky byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wr_data;
        end else if (merge_en) begin
            ctrl_q[STICKY_LSB +: 8] <= ctrl_q[STICKY_LSB +: 8] | merge_flags;
        end
    end

    // Expose the enable byte to the encoder.
    always_comb en_byte = ctrl_q[EN_LSB +: 8];

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !merge_en) |=> $stable(ctrl_q)); // R9
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && merge_en) |=>
        ((ctrl_q[STICKY_LSB +: 8] & $past(ctrl_q[STICKY_LSB +: 8]))
            == $past(ctrl_q[STICKY_LSB +: 8]))); // R8

endmodule

// File: rtl/vfp_trap_encoder.sv
// Top level of the vector FP exception trap encoder. Connects the control
// word, the per-lane priority encoder and the lane sequencer.
// Assumes lanes are reported one per cycle by the arithmetic datapath.
module vfp_trap_encoder
    import vfte_pkg::*;
#(
    parameter int LANES = 4,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int CNT_W  = $clog2(LANES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr_en,
    input  logic [31:0]       ctrl_wr_data,
    output logic [31:0]       ctrl_q,
    input  logic              op_start,
    input  logic              op_single,
    input  logic              op_no_inexact_trap,
    input  logic [CNT_W-1:0]  op_lane_count,
    input  logic              lane_valid,
    input  logic [LANE_W-1:0] lane_idx,
    input  logic [4:0]        lane_flags,
    output logic              busy,
    output logic              trap_pulse,
    output logic [7:0]        trap_code,
    output logic              done,
    output logic              dest_we
);

    cbyte_t     en_byte;
    cbyte_t     merge_flags;
    logic       merge_en;
    logic       sup_cfg;
    logic       lane_trap;
    logic [7:0] lane_code;

    vfte_ctrl_reg u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (ctrl_wr_en),
        .wr_data     (ctrl_wr_data),
        .merge_en    (merge_en),
        .merge_flags (merge_flags),
        .ctrl_q      (ctrl_q),
        .en_byte     (en_byte)
    );

    vfte_prio_enc #(.LANE_W(LANE_W)) u_enc (
        .lane_idx    (lane_idx),
        .lane_flags  (lane_flags),
        .en_byte     (en_byte),
        .sup_inexact (sup_cfg),
        .code        (lane_code),
        .trap        (lane_trap)
    );

    vfte_lane_seq #(.LANES(LANES)) u_seq (
        .clk                (clk),
        .rst_n              (rst_n),
        .op_start           (op_start),
        .op_single          (op_single),
        .op_no_inexact_trap (op_no_inexact_trap),
        .op_lane_count      (op_lane_count),
        .lane_valid         (lane_valid),
        .lane_flags         (lane_flags),
        .lane_trap          (lane_trap),
        .lane_code          (lane_code),
        .sup_cfg            (sup_cfg),
        .busy               (busy),
        .trap_pulse         (trap_pulse),
        .trap_code          (trap_code),
        .done               (done),
        .dest_we            (dest_we),
        .merge_en           (merge_en),
        .merge_flags        (merge_flags)
    );

    AST_TRAP_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_pulse && !$past(ctrl_wr_en)) |-> $stable(ctrl_q)); // R9

endmodule

// File: tb/vfp_trap_encoder_bench.sv
// Bench: a vector table of single-lane operations, then directed tests.
module vfp_trap_encoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr_en = 1'b0;
    logic [31:0] ctrl_wr_data = '0;
    logic [31:0] ctrl_q;
    logic        op_start = 1'b0;
    logic        op_single = 1'b0;
    logic        op_no_inexact_trap = 1'b0;
    logic [2:0]  op_lane_count = '0;
    logic        lane_valid = 1'b0;
    logic [1:0]  lane_idx = '0;
    logic [4:0]  lane_flags = '0;
    logic        busy, trap_pulse, done, dest_we;
    logic [7:0]  trap_code;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk; // 250 MHz

    vfp_trap_encoder u_vfp_trap_encoder (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data), .ctrl_q(ctrl_q),
        .op_start(op_start), .op_single(op_single),
        .op_no_inexact_trap(op_no_inexact_trap), .op_lane_count(op_lane_count),
        .lane_valid(lane_valid), .lane_idx(lane_idx), .lane_flags(lane_flags),
        .busy(busy), .trap_pulse(trap_pulse), .trap_code(trap_code),
        .done(done), .dest_we(dest_we)
    );

    // {enable[7:0], flags[4:0], suppress, idx[3:0], expected code[7:0]}
    localparam int NV = 12;
    localparam logic [25:0] VEC [NV] = '{
        {8'hF8, 5'b10000, 1'b0, 4'd2, 8'h21},  // R2 invalid
        {8'hF8, 5'b01000, 1'b0, 4'd1, 8'h12},  // R2 divide by zero
        {8'hF8, 5'b11111, 1'b0, 4'd3, 8'h31},  // R4 all set -> invalid
        {8'hF8, 5'b00111, 1'b0, 4'd0, 8'h03},  // R4 overflow wins
        {8'hF8, 5'b00011, 1'b0, 4'd2, 8'h24},  // R4 underflow wins
        {8'hF8, 5'b00001, 1'b0, 4'd1, 8'h15},  // R2 inexact
        {8'hF8, 5'b00001, 1'b1, 4'd1, 8'h00},  // R5 suppressed
        {8'h08, 5'b11110, 1'b0, 4'd3, 8'h00},  // R3 disabled conditions
        {8'h48, 5'b10111, 1'b0, 4'd2, 8'h25},  // R3 only inexact enabled
        {8'h00, 5'b11111, 1'b0, 4'd0, 8'h00},  // R3 nothing enabled
        {8'h18, 5'b00011, 1'b1, 4'd0, 8'h04},  // R5 other causes kept
        {8'hA0, 5'b01100, 1'b0, 4'd1, 8'h13}   // R3 overflow enabled
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(logic [31:0] v);
        @(negedge clk);
        ctrl_wr_en = 1'b1; ctrl_wr_data = v;
        @(negedge clk);
        ctrl_wr_en = 1'b0;
    endtask

    task automatic start_op(logic [2:0] cnt, logic single, logic sup);
        @(negedge clk);
        op_start = 1'b1; op_lane_count = cnt; op_single = single;
        op_no_inexact_trap = sup;
        @(negedge clk);
        op_start = 1'b0;
    endtask

    // Drive one lane, then stand at the next falling edge to sample.
    task automatic send_lane(logic [1:0] idx, logic [4:0] fl);
        lane_valid = 1'b1; lane_idx = idx; lane_flags = fl;
        @(negedge clk);
        lane_valid = 1'b0; lane_flags = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ctrl", ctrl_q, 32'h0);
        chk("R1 pulses", {busy, trap_pulse, done, dest_we}, 4'b0);
        chk("R1 code", trap_code, 8'h00);

        // R10: lane while idle does nothing
        send_lane(2'd1, 5'b11111);
        chk("R10 idle lane", {trap_pulse, done, dest_we}, 3'b0);
        chk("R10 idle ctrl", ctrl_q, 32'h0);

        // R11: control write
        wr_ctrl(32'h12345678);
        chk("R11 write", ctrl_q, 32'h12345678);

        // Vector table, one lane per operation
        for (int i = 0; i < NV; i++) begin
            logic [7:0] en, code;
            logic [4:0] fl;
            logic       sup;
            logic [3:0] idx;
            {en, fl, sup, idx, code} = VEC[i];
            wr_ctrl({en, 24'h0});
            start_op(3'd1, 1'b0, sup);
            send_lane(idx[1:0], fl);
            chk("R2 code", trap_code, code);
            chk("R9 trap/dest", {trap_pulse, dest_we, done},
                {code != 0, code == 0, 1'b1});
            chk("R8 sticky", ctrl_q, {en, (code == 0) ? {fl, 3'b0} : 8'h00, 16'h0});
        end

        // R8/R12: four clean lanes, sticky OR onto preloaded flag
        wr_ctrl(32'h0040_0000);
        start_op(3'd4, 1'b0, 1'b0);
        send_lane(2'd0, 5'b00001);
        chk("R12 no early done", done, 1'b0);
        send_lane(2'd1, 5'b00010);
        chk("R12 no early done", done, 1'b0);
        send_lane(2'd2, 5'b00000);
        chk("R12 no early done", done, 1'b0);
        chk("R8 no early merge", ctrl_q, 32'h0040_0000);
        send_lane(2'd3, 5'b10000);
        chk("R12 done pulse", {done, dest_we, trap_pulse}, 3'b110);
        chk("R8 merged flags", ctrl_q, 32'h00D8_0000);
        @(negedge clk);
        chk("R12 one cycle", {done, dest_we}, 2'b00);

        // R6/R9: trap at lane 1, later lane ignored
        wr_ctrl(32'h8000_0000);
        start_op(3'd4, 1'b0, 1'b0);
        send_lane(2'd0, 5'b00100);
        chk("R6 lane0 no trap", {done, trap_pulse}, 2'b00);
        send_lane(2'd1, 5'b10000);
        chk("R6 trap", {trap_pulse, done, dest_we}, 3'b110);
        chk("R2 trap code", trap_code, 8'h11);
        chk("R9 ctrl unchanged", ctrl_q, 32'h8000_0000);
        send_lane(2'd2, 5'b10000);
        chk("R6 ignored after trap", {trap_pulse, done, dest_we}, 3'b000);
        chk("R6 ctrl after trap", ctrl_q, 32'h8000_0000);

        // R8: accumulator cleared at start (lane0 overflow must not leak)
        start_op(3'd1, 1'b0, 1'b0);
        send_lane(2'd0, 5'b00000);
        chk("R8 clear on start", {done, dest_we}, 2'b11);
        chk("R8 no leak", ctrl_q, 32'h8000_0000);

        // R7: single-element mode stops after lane 0
        wr_ctrl(32'h0);
        start_op(3'd4, 1'b1, 1'b0);
        send_lane(2'd0, 5'b00010);
        chk("R7 single done", {done, dest_we}, 2'b11);
        chk("R7 single flags", ctrl_q, 32'h0010_0000);
        send_lane(2'd1, 5'b10000);
        chk("R7 later lane ignored", {done, dest_we}, 2'b00);
        chk("R7 ctrl kept", ctrl_q, 32'h0010_0000);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule